// File: doc/BRIEF.md
# Byte/Word Dual-Read Register File

This block is the operand store of a 16-bit datapath. It holds sixteen 16-bit registers in four byte-wide banks of eight entries: two banks carry the low byte lane and two carry the high byte lane. Two read ports, addressed by a source index and a destination index, return register contents combinationally. One write port updates the register named by the destination index on the rising clock edge.

In byte mode, a byte address 0 to 15 selects the low byte of the register with the same number, and the high lane takes no part. A byte read returns the byte on bits 7..0. Bits 15..8 are filled with zeros or with a copy of the byte, chosen by a fill input. A byte write changes that one low-lane byte and nothing else.

Double-word and quad-word operands are handled by a small sequencer. After a start strobe it walks both ports through two or four consecutive registers, one per clock, and reports busy and done. A parameter can tie the source port to register 0, so that the file behaves as an accumulator machine's register set.

Top module: `rf_dual_read`

## Requirements
- R1: While reset (rstN low) is applied and after it is released, every register reads 0000 and busy, done and err are low.
- R2: With byteMode low and the sequencer idle, srcRd shows register srcAddr and dstRd shows register dstAddr in the same cycle. When wrEn is high, wrData is written to register dstAddr at the clock edge, and a read of that register in the same cycle still returns the old value.
- R3: With byteMode high and the sequencer idle, each read port returns the low byte of the addressed register on bits 7..0. Bits 15..8 are 00 when fillRep is 0 and a copy of the byte when fillRep is 1.
- R4: A write with byteMode high and the sequencer idle replaces only bits 7..0 of register dstAddr. Its high byte and every other register keep their contents.
- R5: The opSize encoding is 00 single, 01 double and 1x quad. An idle start (startOp high with a non-single opSize) and an aligned base performs no access in the start cycle. In the following 2 (double) or 4 (quad) cycles, busy is high and the ports use base+k for k = 0, 1, and so on, on both the source and the destination side, where the base is the address captured at the start. In each of these cycles, wrEn writes wrData to the current destination register.
- R6: done is high only during the last access cycle of a sequence. busy goes low in the cycle after that.
- R7: A double start with an odd base, or a quad start with a base that is not a multiple of 4 (on either port), raises err for exactly the next cycle. It starts no sequence and writes nothing.
- R8: The start cycle never writes, even with wrEn high. startOp is ignored while busy. byteMode is ignored during a sequence, which always makes full-word accesses.
- R9: With parameter FIX_SRC_ZERO set, srcRd always shows register 0, whatever srcAddr holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| byteMode | input | 1 | 1 = byte access to the low lane, 0 = word access |
| fillRep | input | 1 | Byte-read upper fill: 0 = zeros, 1 = replicate byte |
| srcAddr | input | 4 | Source register or byte index |
| dstAddr | input | 4 | Destination register or byte index, also the write index |
| wrEn | input | 1 | Write enable |
| wrData | input | 16 | Write data |
| opSize | input | 2 | Operand size: 00 single, 01 double, 1x quad |
| startOp | input | 1 | Start strobe for a multi-word sequence |
| srcRd | output | 16 | Source read bus |
| dstRd | output | 16 | Destination read bus |
| busy | output | 1 | Multi-word sequence in progress |
| done | output | 1 | Final access cycle of a sequence |
| err | output | 1 | One-cycle misaligned-base flag |

## Verification
The bench checks the same-cycle read of a register being written. A design that forwards write data would show the new value there. Byte writes are read back as words, which catches a design that disturbs the high lane or zero-fills on write. It also compares zero fill against replicate fill on the same bytes.

For sequences, the bench checks when done rises, checks that busy is not re-armed by a start during busy, and checks that a word access survives byteMode being raised mid-sequence. It also drives wrEn in the start cycle and shows that this write is blocked. A sequencer that is off by one cycle, or that leaks the start-cycle write, would show a wrong destination value in the first access cycle. Misaligned bases on either port must set err without moving busy or changing the target register.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int LANE_W  = 8;
  localparam int WORD_W  = 2 * LANE_W;
  localparam int N_BANKS = 4;

  localparam logic [1:0] SZ_SINGLE = 2'b00;
  localparam logic [1:0] SZ_DOUBLE = 2'b01;

  // Strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic seqOn;    // a multi-word access is in progress
    logic wrBlock;  // current cycle must not write
  } rfCtl_t;
endpackage

// File: rtl/rf_seq.sv
module rf_seq
  import rf_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter bit FIX_SRC_ZERO = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startOp,
  input  logic [1:0]        opSize,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  output rfCtl_t            ctl,
  output logic [ADDR_W-1:0] srcSel,
  output logic [ADDR_W-1:0] dstSel,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic              busyR, errR;
  logic [1:0]        stepCnt, lastStep;
  logic [ADDR_W-1:0] srcBase, dstBase, srcIn;
  logic              wantQuad, startGo, misaligned;
  logic [1:0]        alignMask;

  assign srcIn      = FIX_SRC_ZERO ? '0 : srcAddr;
  assign wantQuad   = opSize[1];
  assign alignMask  = wantQuad ? 2'b11 : 2'b01;
  assign misaligned = ((srcIn[1:0] | dstAddr[1:0]) & alignMask) != 2'b00;
  assign startGo    = !busyR && startOp && (opSize != SZ_SINGLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR    <= 1'b0;
      errR     <= 1'b0;
      stepCnt  <= '0;
      lastStep <= '0;
      srcBase  <= '0;
      dstBase  <= '0;
    end else begin
      errR <= startGo && misaligned;
      if (busyR) begin
        stepCnt <= stepCnt + 2'd1;
        if (stepCnt == lastStep) busyR <= 1'b0;
      end else if (startGo && !misaligned) begin
        busyR    <= 1'b1;
        stepCnt  <= '0;
        lastStep <= wantQuad ? 2'd3 : 2'd1;
        srcBase  <= srcIn;
        dstBase  <= dstAddr;
      end
    end
  end

  assign srcSel      = busyR ? srcBase + ADDR_W'(stepCnt) : srcIn;
  assign dstSel      = busyR ? dstBase + ADDR_W'(stepCnt) : dstAddr;
  assign done        = busyR && (stepCnt == lastStep);
  assign busy        = busyR;
  assign err         = errR;
  assign ctl.seqOn   = busyR;
  assign ctl.wrBlock = startGo;

  // R5: consecutive addresses inside a sequence
  a_r5_consecutive: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && stepCnt != 2'd0) |-> (dstSel == ADDR_W'($past(dstSel) + 1'b1)));
  // R6: busy only ends after a done cycle
  a_r6_done_before_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyR) |-> $past(done));
  // R6: done is the last busy cycle
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busyR);
  // R7: an error never coincides with a running sequence
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    errR |-> !busyR);
endmodule

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
#(
  parameter int BANK_DEPTH = 8,
  localparam int REG_COUNT = 2 * BANK_DEPTH,
  localparam int ADDR_W    = $clog2(REG_COUNT),
  localparam int ENT_W     = $clog2(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfCtl_t            ctl,
  input  logic              byteMode,
  input  logic              fillRep,
  input  logic [ADDR_W-1:0] srcSel,
  input  logic [ADDR_W-1:0] dstSel,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] srcRd,
  output logic [WORD_W-1:0] dstRd
);
  // bank {half,0} = low lane, bank {half,1} = high lane
  logic [N_BANKS-1:0][BANK_DEPTH-1:0][LANE_W-1:0] mem;
  logic              byteEff, wrGo;
  logic [1:0]        dstLoBank, dstHiBank;
  logic [ENT_W-1:0]  dstEnt;
  logic [WORD_W-1:0] srcWord, dstWord;

  function automatic logic [WORD_W-1:0] fetchWord(
      input logic [N_BANKS-1:0][BANK_DEPTH-1:0][LANE_W-1:0] m,
      input logic [ADDR_W-1:0] a);
    return {m[{a[ADDR_W-1], 1'b1}][a[ENT_W-1:0]], m[{a[ADDR_W-1], 1'b0}][a[ENT_W-1:0]]};
  endfunction

  function automatic logic [WORD_W-1:0] shapeRead(
      input logic [WORD_W-1:0] w, input logic asByte, input logic rep);
    if (!asByte) return w;
    return {(rep ? w[LANE_W-1:0] : {LANE_W{1'b0}}), w[LANE_W-1:0]};
  endfunction

  assign byteEff   = byteMode && !ctl.seqOn;
  assign wrGo      = wrEn && !ctl.wrBlock;
  assign dstLoBank = {dstSel[ADDR_W-1], 1'b0};
  assign dstHiBank = {dstSel[ADDR_W-1], 1'b1};
  assign dstEnt    = dstSel[ENT_W-1:0];

  assign srcWord = fetchWord(mem, srcSel);
  assign dstWord = fetchWord(mem, dstSel);
  assign srcRd   = shapeRead(srcWord, byteEff, fillRep);
  assign dstRd   = shapeRead(dstWord, byteEff, fillRep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem <= '0;
    end else if (wrGo) begin
      mem[dstLoBank][dstEnt] <= wrData[LANE_W-1:0];
      if (!byteEff) mem[dstHiBank][dstEnt] <= wrData[WORD_W-1:LANE_W];
    end
  end

  // R8 / R7: a blocked start cycle leaves every byte untouched
  a_r8_blocked_no_write: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrBlock |=> $stable(mem));
  // R4: a byte write keeps the high lane of its register
  a_r4_high_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrGo && byteEff) |=>
      (mem[$past(dstHiBank)][$past(dstEnt)] == $past(mem[dstHiBank][dstEnt])));
endmodule

// File: rtl/rf_dual_read.sv
module rf_dual_read
  import rf_pkg::*;
#(
  parameter int BANK_DEPTH   = 8,
  parameter bit FIX_SRC_ZERO = 1'b0
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              byteMode,
  input  logic                              fillRep,
  input  logic [$clog2(2*BANK_DEPTH)-1:0]   srcAddr,
  input  logic [$clog2(2*BANK_DEPTH)-1:0]   dstAddr,
  input  logic                              wrEn,
  input  logic [15:0]                       wrData,
  input  logic [1:0]                        opSize,
  input  logic                              startOp,
  output logic [15:0]                       srcRd,
  output logic [15:0]                       dstRd,
  output logic                              busy,
  output logic                              done,
  output logic                              err
);
  localparam int ADDR_W = $clog2(2 * BANK_DEPTH);

  rfCtl_t            ctl;
  logic [ADDR_W-1:0] srcSel, dstSel;

  rf_seq #(.ADDR_W(ADDR_W), .FIX_SRC_ZERO(FIX_SRC_ZERO)) u_seq (
    .clk(clk), .rstN(rstN), .startOp(startOp), .opSize(opSize),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .ctl(ctl),
    .srcSel(srcSel), .dstSel(dstSel), .busy(busy), .done(done), .err(err)
  );

  rf_store #(.BANK_DEPTH(BANK_DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteMode(byteMode), .fillRep(fillRep),
    .srcSel(srcSel), .dstSel(dstSel), .wrEn(wrEn), .wrData(wrData),
    .srcRd(srcRd), .dstRd(dstRd)
  );
endmodule

// File: tb/rf_dual_read_bench.sv
module rf_dual_read_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteMode = 1'b0, fillRep = 1'b0, wrEn = 1'b0, startOp = 1'b0;
  logic [3:0]  srcAddr = '0, dstAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  opSize = '0;
  logic [15:0] srcRd, dstRd, accSrcRd, accDstRd;
  logic busy, done, err, accBusy, accDone, accErr;
  int nChecks = 0, nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  rf_dual_read u_rf_dual_read (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .fillRep(fillRep),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .wrEn(wrEn), .wrData(wrData),
    .opSize(opSize), .startOp(startOp), .srcRd(srcRd), .dstRd(dstRd),
    .busy(busy), .done(done), .err(err));

  rf_dual_read #(.FIX_SRC_ZERO(1'b1)) u_rf_dual_read_acc (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .fillRep(fillRep),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .wrEn(wrEn), .wrData(wrData),
    .opSize(opSize), .startOp(startOp), .srcRd(accSrcRd), .dstRd(accDstRd),
    .busy(accBusy), .done(accDone), .err(accErr));

  typedef struct packed {
    logic bm, fr, we;
    logic [3:0] src, dst;
    logic [15:0] wd, es, ed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 4'd0,  4'd3,  16'h1234, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 4'd3,  4'd5,  16'hABCD, 16'h1234, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 4'd5,  4'd3,  16'h0000, 16'hABCD, 16'h1234},
    '{1'b1, 1'b0, 1'b0, 4'd3,  4'd5,  16'h0000, 16'h0034, 16'h00CD},
    '{1'b1, 1'b1, 1'b0, 4'd3,  4'd5,  16'h0000, 16'h3434, 16'hCDCD},
    '{1'b1, 1'b0, 1'b1, 4'd3,  4'd3,  16'hEE77, 16'h0034, 16'h0034},
    '{1'b0, 1'b0, 1'b0, 4'd3,  4'd5,  16'h0000, 16'h1277, 16'hABCD},
    '{1'b0, 1'b0, 1'b1, 4'd15, 4'd15, 16'hFFFF, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 1'b0, 4'd15, 4'd0,  16'h0000, 16'hFFFF, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 4'd15, 4'd0,  16'h0000, 16'hFFFF, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    srcAddr = 4'd9; dstAddr = 4'd14;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 busy in reset", {15'b0, busy}, 16'h0000);
    chk("R1 src in reset", srcRd, 16'h0000);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 flags", {13'b0, busy, done, err}, 16'h0000);
    chk("R1 dst after reset", dstRd, 16'h0000);

    // Table: single accesses, word and byte (R2 R3 R4)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      byteMode = VECS[i].bm; fillRep = VECS[i].fr; wrEn = VECS[i].we;
      srcAddr = VECS[i].src; dstAddr = VECS[i].dst; wrData = VECS[i].wd;
      #1;
      chk(i == 6 ? "R4 src" : (VECS[i].bm ? "R3 src" : "R2 src"), srcRd, VECS[i].es);
      chk(i == 6 ? "R4 dst" : (VECS[i].bm ? "R3 dst" : "R2 dst"), dstRd, VECS[i].ed);
    end

    // Double sequence, start-cycle write must be blocked (R5 R6 R8)
    @(negedge clk);
    byteMode = 1'b0; fillRep = 1'b0; opSize = 2'b01; srcAddr = 4'd4; dstAddr = 4'd6;
    startOp = 1'b1; wrEn = 1'b1; wrData = 16'hDEAD;
    #1 chk("R5 no busy in start cycle", {15'b0, busy}, 16'h0000);
    @(negedge clk);
    startOp = 1'b0; wrData = 16'h1111; srcAddr = 4'd0; dstAddr = 4'd0;
    #1;
    chk("R5 busy step0", {15'b0, busy}, 16'h0001);
    chk("R6 done step0", {15'b0, done}, 16'h0000);
    chk("R5 src step0", srcRd, 16'h0000);
    chk("R8 start write blocked", dstRd, 16'h0000);
    @(negedge clk);
    wrData = 16'h2222; byteMode = 1'b1;
    #1;
    chk("R6 done step1", {15'b0, done}, 16'h0001);
    chk("R8 byteMode ignored in sequence", srcRd, 16'hABCD);
    chk("R5 dst step1 old", dstRd, 16'h0000);
    @(negedge clk);
    wrEn = 1'b0; byteMode = 1'b0; opSize = 2'b00; srcAddr = 4'd6; dstAddr = 4'd7;
    #1;
    chk("R6 idle after", {14'b0, busy, done}, 16'h0000);
    chk("R5 double write lo", srcRd, 16'h1111);
    chk("R5 double write hi", dstRd, 16'h2222);

    // Quad sequence with a start during busy (R5 R6 R8)
    @(negedge clk);
    opSize = 2'b10; srcAddr = 4'd8; dstAddr = 4'd12; startOp = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      startOp = (k == 1); opSize = (k == 1) ? 2'b01 : 2'b10;
      srcAddr = 4'd2; dstAddr = 4'd2;
      wrEn = 1'b1; wrData = 16'h00A0 + 16'(k);
      #1;
      chk("R5 quad busy", {15'b0, busy}, 16'h0001);
      chk("R6 quad done", {15'b0, done}, (k == 3) ? 16'h0001 : 16'h0000);
      chk("R5 quad dst old", dstRd, (k == 3) ? 16'hFFFF : 16'h0000);
    end
    @(negedge clk);
    startOp = 1'b0; wrEn = 1'b0; opSize = 2'b00; srcAddr = 4'd12; dstAddr = 4'd15;
    #1;
    chk("R8 start in busy ignored", {15'b0, busy}, 16'h0000);
    chk("R5 quad first", srcRd, 16'h00A0);
    chk("R5 quad last", dstRd, 16'h00A3);

    // Misaligned double (odd dst) and quad (dst 6) (R7)
    @(negedge clk);
    opSize = 2'b01; srcAddr = 4'd4; dstAddr = 4'd5; startOp = 1'b1;
    wrEn = 1'b1; wrData = 16'hBEEF;
    @(negedge clk);
    startOp = 1'b0; wrEn = 1'b0; opSize = 2'b00; srcAddr = 4'd5; dstAddr = 4'd5;
    #1;
    chk("R7 err set", {15'b0, err}, 16'h0001);
    chk("R7 no busy", {15'b0, busy}, 16'h0000);
    chk("R7 no write", srcRd, 16'hABCD);
    @(negedge clk);
    #1 chk("R7 err one cycle", {15'b0, err}, 16'h0000);
    @(negedge clk);
    opSize = 2'b10; srcAddr = 4'd8; dstAddr = 4'd6; startOp = 1'b1;
    @(negedge clk);
    startOp = 1'b0; opSize = 2'b00;
    #1;
    chk("R7 quad err", {15'b0, err}, 16'h0001);
    chk("R7 quad no busy", {15'b0, busy}, 16'h0000);

    // Accumulator variant (R9)
    @(negedge clk);
    wrEn = 1'b1; dstAddr = 4'd0; wrData = 16'h5A5A; srcAddr = 4'd5;
    @(negedge clk);
    wrEn = 1'b0; dstAddr = 4'd6;
    #1;
    chk("R9 acc src fixed", accSrcRd, 16'h5A5A);
    chk("R9 normal src", srcRd, 16'hABCD);
    chk("R9 acc dst free", accDstRd, 16'h1111);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule